// File: doc/BRIEF.md
# Write-Only I2C Configuration Slave

This block lets a board controller load a bank of six byte-wide configuration registers for a clock generator over a two-wire I2C bus. The bus lines arrive as open-drain levels. The block brings them into the system clock domain itself, through a short flop chain. The only transfer it accepts is a block write:

1. A START condition.
2. The device address byte, 0xD2.
3. Two framing bytes, a command code and a byte count. Both are acknowledged and their values are thrown away.
4. Data bytes, which fill the registers in fixed ascending order until a STOP arrives.

Nothing can be read back. The block never stretches the clock. Its only drive onto the bus is an enable that pulls SDA low during acknowledge bits.

The register contents are presented continuously on a flat output vector. A power-down input freezes the interface. While it is high the bus is ignored, and the registers keep whatever was last written.

Top module: `cfg_i2c_write_slave`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cfg_o` holds the power-on defaults. Register k sits at bits [8k+7:8k]. Register 0 is 0x0C and registers 1 to 5 are 0xFF.
- R2: An address byte equal to 0xD2 (7-bit address 0x69 followed by a 0 write bit) is acknowledged: `sda_oe_o` pulls SDA low while SCL is high in the ninth clock of that byte.
- R3: Any other address byte is not acknowledged, including the read form 0xD3. No byte of the rest of that transfer is acknowledged, and no register changes.
- R4: After a matched address, every complete byte is acknowledged. This covers the two framing bytes and each data byte.
- R5: The two bytes following the address are discarded whatever their values. A transfer that ends after them leaves every register unchanged.
- R6: The data bytes after the framing bytes are written to register 0, then 1, 2, 3, 4 and 5, in that order.
- R7: A STOP after any complete byte ends the transfer. Registers written before it keep their new values, and the others keep their old ones.
- R8: A data byte cut short by a STOP or a repeated START changes no register.
- R9: Data bytes beyond register 5 are acknowledged but not stored.
- R10: While `pdn_i` is high, the bus is ignored: no acknowledge is driven and `cfg_o` does not change. A transfer interrupted by `pdn_i` is abandoned, and the block waits for a fresh START.
- R11: A repeated START returns the block to the address phase. The next data byte again goes to register 0.
- R12: `sda_oe_o` is low outside acknowledge bits. It is released again after the SCL falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above 4x the SCL rate |
| rst | input | 1 | Synchronous active-high reset, restores register defaults |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| pdn_i | input | 1 | Power-down: freezes the interface and the registers |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| cfg_o | output | 48 | Six configuration registers, register k at bits [8k+7:8k] |

## Verification
The hardest situations to reach from the ports are the partial ones. Examples are a STOP or a repeated START arriving a few bits into a data byte, and the power-down input rising between two acknowledged bytes while the master keeps clocking. The bench drives these with a bit-level master model. That model can emit any number of bits of a byte before issuing a bus condition, so these interruptions are reachable.

A sweep of all 256 possible address bytes checks that exactly one is acknowledged. A sweep of transfer lengths from zero to eight data bytes walks the register pointer through its last register and past it. Each transfer is checked against a register model held in the bench.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RECV = 2'd1,
    ENG_ACK  = 2'd2
  } eng_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/cfgi2c_bus_sync.sv
module cfgi2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;
  logic              sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  // bus conditions: SDA edge while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign sda_o      = sda_s;
endmodule

// File: rtl/cfgi2c_byte_engine.sv
module cfgi2c_byte_engine
  import cfgi2c_pkg::*;
#(
  parameter int         NUM_REGS    = 6,
  parameter int         DUMMY_BYTES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         IDX_W       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int SEQ_MAX = 1 + DUMMY_BYTES + NUM_REGS;
  localparam int SEQ_W   = $clog2(SEQ_MAX + 1);
  localparam logic [SEQ_W-1:0]  FIRST_DATA = SEQ_W'(1 + DUMMY_BYTES);
  localparam logic [SEQ_W-1:0]  SEQ_LAST   = SEQ_W'(SEQ_MAX);
  localparam logic [BYTE_W-1:0] ADDR_WR    = {DEV_ADDR, 1'b0};

  eng_state_t        state;
  logic [SEQ_W-1:0]  seq_cnt;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk) begin
    wr_en_o <= 1'b0;
    if (rst) begin
      state     <= ENG_IDLE;
      sda_oe_o  <= 1'b0;
      seq_cnt   <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else if (freeze_i || stop_i) begin
      state    <= ENG_IDLE;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      state    <= ENG_RECV;
      sda_oe_o <= 1'b0;
      seq_cnt  <= '0;
      bit_cnt  <= '0;
    end else begin
      case (state)
        ENG_RECV: begin
          if (scl_rise_i && bit_cnt < 4'd8) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall_i && bit_cnt == 4'd8) begin
            if (seq_cnt == '0) begin
              if (shreg == ADDR_WR) begin
                state    <= ENG_ACK;
                sda_oe_o <= 1'b1;
              end else begin
                state <= ENG_IDLE;
              end
            end else begin
              state    <= ENG_ACK;
              sda_oe_o <= 1'b1;
              if (seq_cnt >= FIRST_DATA && seq_cnt < SEQ_LAST) begin
                wr_en_o   <= 1'b1;
                wr_idx_o  <= IDX_W'(seq_cnt - FIRST_DATA);
                wr_data_o <= shreg;
              end
            end
          end
        end
        ENG_ACK: begin
          if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state    <= ENG_RECV;
            bit_cnt  <= '0;
            if (seq_cnt != SEQ_LAST) seq_cnt <= seq_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgi2c_reg_bank.sv
module cfgi2c_reg_bank
  import cfgi2c_pkg::*;
#(
  parameter int                           NUM_REGS = 6,
  parameter int                           IDX_W    = $clog2(NUM_REGS),
  parameter logic [NUM_REGS*BYTE_W-1:0]   DEFAULTS = 48'hFFFF_FFFF_FF0C
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         freeze_i,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  output logic [NUM_REGS*BYTE_W-1:0]   cfg_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= DEFAULTS[g*BYTE_W +: BYTE_W];
      end else if (wr_en_i && !freeze_i && wr_idx_i == IDX_W'(g)) begin
        byte_q <= wr_data_i;
      end
    end
    assign cfg_o[g*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/cfg_i2c_write_slave.sv
module cfg_i2c_write_slave
  import cfgi2c_pkg::*;
#(
  parameter int                         NUM_REGS    = 6,
  parameter int                         DUMMY_BYTES = 2,
  parameter logic [6:0]                 DEV_ADDR    = 7'h69,
  parameter int                         SYNC_STAGES = 2,
  parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS    = 48'hFFFF_FFFF_FF0C
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       pdn_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic              sda_s;
  logic              start_det;
  logic              stop_det;
  logic              scl_rise;
  logic              scl_fall;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  cfgi2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  cfgi2c_byte_engine #(
    .NUM_REGS    (NUM_REGS),
    .DUMMY_BYTES (DUMMY_BYTES),
    .DEV_ADDR    (DEV_ADDR),
    .IDX_W       (IDX_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .freeze_i   (pdn_i),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  cfgi2c_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .DEFAULTS (DEFAULTS)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .freeze_i  (pdn_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .cfg_o     (cfg_o)
  );
endmodule

// File: rtl/cfg_i2c_write_slave_chk.sv
module cfg_i2c_write_slave_chk #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pdn_i,
  input logic                  sda_oe_o,
  input logic                  stop_det,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [NUM_REGS*8-1:0] cfg_o
);
  p_pdn_holds_cfg_r10: assert property (@(posedge clk) disable iff (rst)
    pdn_i |=> $stable(cfg_o));

  p_pdn_no_ack_r10: assert property (@(posedge clk) disable iff (rst)
    pdn_i |=> !sda_oe_o);

  p_stop_releases_r7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe_o);

  p_write_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < NUM_REGS));

  p_write_single_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_cfg_moves_on_write_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> $past(wr_en));
endmodule

bind cfg_i2c_write_slave cfg_i2c_write_slave_chk #(
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pdn_i    (pdn_i),
  .sda_oe_o (sda_oe_o),
  .stop_det (stop_det),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .cfg_o    (cfg_o)
);

// File: tb/cfg_i2c_write_slave_bench.sv
module cfg_i2c_write_slave_bench;
  localparam int Q  = 6;
  localparam int WD = 180000;
  localparam logic [47:0] DEF = 48'hFFFF_FFFF_FF0C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic pdn = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [47:0] cfg;
  logic [47:0] exp_cfg;
  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  cfg_i2c_write_slave u_cfg_i2c_write_slave (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .pdn_i    (pdn),
    .sda_oe_o (sda_oe),
    .cfg_o    (cfg)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b1; hold();
    hold();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_sda = b[7-i]; hold();
      m_scl = 1'b1; hold(); hold();
      m_scl = 1'b0; hold();
    end
  endtask

  // returns 1 when the slave pulled SDA low in the ninth clock
  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    acked = (sda_line == 1'b0);
    hold();
    m_scl = 1'b0; hold();
    check(sda_oe == 1'b0, "R12 release after ninth clock", {47'b0, sda_oe}, 48'b0);
  endtask

  function automatic logic [7:0] dval(input int n, input int k);
    return 8'((n * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic write_txn(input int n);
    bit ack;
    bus_start();
    send_byte(8'hD2, ack);
    check(ack, "R2 address ack", {47'b0, ack}, 48'b1);
    send_byte(8'h5A, ack);
    check(ack, "R4 R5 command byte ack", {47'b0, ack}, 48'b1);
    send_byte(8'hC3, ack);
    check(ack, "R4 R5 count byte ack", {47'b0, ack}, 48'b1);
    for (int k = 0; k < n; k++) begin
      send_byte(dval(n, k), ack);
      if (k < 6) begin
        check(ack, "R4 data ack", {47'b0, ack}, 48'b1);
        exp_cfg[k*8 +: 8] = dval(n, k);
      end else begin
        check(ack, "R9 extra byte ack", {47'b0, ack}, 48'b1);
      end
    end
    bus_stop();
    check(cfg == exp_cfg, "R6 R7 R9 R5 registers after write", cfg, exp_cfg);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL R4 watchdog: actual %0d cycles expected fewer", WD);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    bit ack;
    repeat (4) @(negedge clk);
    check(cfg == DEF, "R1 defaults during reset", cfg, DEF);
    rst = 1'b0;
    @(negedge clk);
    check(cfg == DEF, "R1 defaults after reset", cfg, DEF);
    check(sda_oe == 1'b0, "R12 idle no drive", {47'b0, sda_oe}, 48'b0);
    exp_cfg = DEF;
    hold();

    // R2 R3: sweep every address byte
    for (int a = 0; a < 256; a++) begin
      bus_start();
      send_byte(8'(a), ack);
      if (a == 8'hD2)
        check(ack, "R2 matching address", {47'b0, ack}, 48'b1);
      else
        check(!ack, "R3 foreign address", {47'b0, ack}, 48'b0);
      bus_stop();
    end
    check(cfg == exp_cfg, "R3 sweep leaves registers", cfg, exp_cfg);

    // R3: read form followed by would-be data
    bus_start();
    send_byte(8'hD3, ack);
    check(!ack, "R3 read address", {47'b0, ack}, 48'b0);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'h10 + 8'(k), ack);
      check(!ack, "R3 bytes after nack", {47'b0, ack}, 48'b0);
    end
    bus_stop();
    check(cfg == exp_cfg, "R3 registers untouched", cfg, exp_cfg);

    // R5 R6 R7 R9: lengths 0..8
    for (int n = 0; n <= 8; n++) write_txn(n);

    // R8: byte cut by STOP
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h01, ack);
    send_byte(8'h02, ack);
    send_byte(8'h77, ack);
    exp_cfg[7:0] = 8'h77;
    send_bits(8'h88, 5);
    bus_stop();
    check(cfg == exp_cfg, "R8 partial byte before stop", cfg, exp_cfg);

    // R11 R8: repeated START mid byte restarts at register 0
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h3C, ack);
    send_bits(8'hF0, 3);
    bus_start();
    send_byte(8'hD2, ack);
    check(ack, "R11 re-address ack", {47'b0, ack}, 48'b1);
    send_byte(8'hAA, ack);
    send_byte(8'hBB, ack);
    send_byte(8'h4D, ack);
    send_byte(8'h5E, ack);
    bus_stop();
    exp_cfg[15:0] = 16'h5E4D;
    check(cfg == exp_cfg, "R11 R8 restart at register 0", cfg, exp_cfg);

    // R10: power-down during a whole transfer
    pdn = 1'b1;
    bus_start();
    send_byte(8'hD2, ack);
    check(!ack, "R10 no ack while powered down", {47'b0, ack}, 48'b0);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h99, ack);
    bus_stop();
    check(cfg == exp_cfg, "R10 registers kept", cfg, exp_cfg);
    pdn = 1'b0;
    hold();

    // R10: power-down between data bytes abandons the transfer
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h61, ack);
    exp_cfg[7:0] = 8'h61;
    pdn = 1'b1;
    send_byte(8'h62, ack);
    check(!ack, "R10 mid transfer freeze", {47'b0, ack}, 48'b0);
    pdn = 1'b0;
    send_byte(8'h63, ack);
    check(!ack, "R10 needs fresh start", {47'b0, ack}, 48'b0);
    bus_stop();
    check(cfg == exp_cfg, "R10 earlier write kept", cfg, exp_cfg);

    // R1: reset restores defaults
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(cfg == DEF, "R1 defaults on second reset", cfg, DEF);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule